// File: doc/BRIEF.md
# TDM Time-Slot Interchange with Message Insertion

This core switches bytes between time slots of serial time-division multiplexed streams. Every bit clock it shifts one bit in from each input stream and one bit out onto each output stream. A frame holds NCHAN byte-wide channels on each of NSTREAM streams. Each complete input byte is stored in a frame-banked data memory. One frame later, that byte can appear in any output slot of any stream.

What each output slot carries is set by two per-slot configuration entries:
- A connection byte. In switching mode it names the source stream and channel. In message mode it is itself the byte that goes out.
- A small control entry, holding a slot enable and a slot message flag.

A global message bit in a control register turns every slot into a message slot and drives it. An output-drive-enable pin can put all outputs into high impedance. Outputs come out as a data bit plus a drive-enable bit per stream, so the pad ring can build the tri-state pin.

The serial streams run at fixed bit rate and cannot be stalled, so there is no valid/ready handshake. Every pin is plain and sampled on each clock edge. A processor loads the configuration through a single-cycle write strobe. Writes are never refused.

Top module: `tsi_switch`

## Requirements
- R1: With a slot in switching mode, output stream s, channel c of frame N carries the byte received on input stream (connection byte bits 7:5), channel (bits 4:0) during frame N-1. The connection byte is written with cfg_sel = 0 at cfg_addr = {s, c}.
- R2: A slot whose control entry bit 2 is 1 drives its whole 8-bit connection byte, provided its enable (bit 0) is 1. The control entry is written with cfg_sel = 1.
- R3: When control register bit 6 is 1, every slot drives its connection byte and every slot is enabled, whatever its own bits 2 and 0 hold. The control register is written with cfg_sel = 2.
- R4: While out_drive_en is 0, every bit of tx_oe is 0.
- R5: While out_drive_en is 1 and the global message bit is 0, a slot whose enable bit is 0 shows tx_oe = 0 for all 8 of its bit times. A slot whose enable bit is 1 shows tx_oe = 1.
- R6: frame_sync high marks bit time 0 of channel 0. Each slot's byte leaves MSB first, in the same bit times in which the matching input bits are taken.
- R7: After reset, all connection entries, control entries and the control register are 0, so tx_oe stays 0 until the configuration is written.
- R8: An input byte from the last channel of a frame is switched into channel 0 of the very next frame without loss, even though it completes on the final bit of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset |
| frame_sync | input | 1 | High for the first bit time of each frame |
| rx_data | input | NSTREAM | One serial input bit per stream |
| out_drive_en | input | 1 | Global output drive enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 connection byte, 1 control entry, 2 control register |
| cfg_addr | input | log2(NSTREAM)+log2(NCHAN) | Slot index {stream, channel} |
| cfg_data | input | BW | Write data |
| tx_data | output | NSTREAM | One serial output bit per stream |
| tx_oe | output | NSTREAM | Drive enable for each output stream |

## Verification
The bench builds the core with 4 streams, 4 channels and 8-bit channels. That makes 16 slots and a 32-cycle frame. At this size every source-to-destination pairing can be swept with rotated and multiplied permutations in a few thousand cycles. The sweep includes the wrap from the last input channel into channel 0 of the next frame. All eight combinations of drive pin, global message bit and slot enable are also covered, each against slot patterns that mix message and switched slots.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

  typedef struct packed {
    logic msg;
    logic oe;
  } cmh_t;

  localparam logic [1:0] SEL_CML  = 2'd0;
  localparam logic [1:0] SEL_CMH  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int CTRL_GMSG_BIT = 6;
  localparam int CMH_MSG_BIT   = 2;
  localparam int CMH_OE_BIT    = 0;

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int NCHAN = 32,
  parameter int BW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_sync,
  output logic [$clog2(NCHAN)-1:0] cur_ch,
  output logic [$clog2(NCHAN)-1:0] nxt_ch,
  output logic                     byte_end,
  output logic                     frame_start,
  output logic                     wbank
);
  localparam int CW   = $clog2(NCHAN);
  localparam int BITW = $clog2(BW);

  logic [BITW-1:0] bit_q, cur_bit;
  logic [CW-1:0]   ch_q;
  logic            last_ch;

  always_comb begin
    cur_bit     = frame_sync ? '0 : bit_q;
    cur_ch      = frame_sync ? '0 : ch_q;
    last_ch     = (cur_ch == CW'(NCHAN - 1));
    nxt_ch      = last_ch ? '0 : cur_ch + CW'(1);
    byte_end    = (cur_bit == BITW'(BW - 1));
    frame_start = (cur_bit == '0) && (cur_ch == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      ch_q  <= '0;
      wbank <= 1'b0;
    end else begin
      if (byte_end) begin
        bit_q <= '0;
        ch_q  <= nxt_ch;
      end else begin
        bit_q <= cur_bit + BITW'(1);
        ch_q  <= cur_ch;
      end
      if (frame_start) wbank <= ~wbank;
    end
  end

  // R6: a sync pulse restarts the count at bit 0 of channel 0
  p_sync_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (bit_q == BITW'(1)) && (ch_q == '0));

  // R1: banks swap once per frame, giving the one-frame delay
  p_bank_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (wbank != $past(wbank)));

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int BW      = 8
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic [NSTREAM-1:0]                                    rx_data,
  input  logic                                                  byte_end,
  input  logic [$clog2(NCHAN)-1:0]                              cur_ch,
  input  logic                                                  wbank,
  input  logic                                                  rd_bank,
  input  logic [NSTREAM-1:0][$clog2(NSTREAM)+$clog2(NCHAN)-1:0] rd_addr,
  output logic [NSTREAM-1:0][BW-1:0]                            rd_byte
);
  localparam int SW    = $clog2(NSTREAM);
  localparam int CW    = $clog2(NCHAN);
  localparam int AW    = SW + CW;
  localparam int DEPTH = 1 << AW;

  logic [NSTREAM-1:0][BW-2:0] sh_q;
  logic [NSTREAM-1:0][BW-1:0] new_byte;
  logic [BW-1:0]              dmem [2][DEPTH];

  for (genvar g = 0; g < NSTREAM; g++) begin : g_assemble
    assign new_byte[g] = {sh_q[g], rx_data[g]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++)
          dmem[b][i] <= '0;
    end else begin
      for (int s = 0; s < NSTREAM; s++) begin
        sh_q[s] <= new_byte[s][BW-2:0];
        if (byte_end) dmem[wbank][{SW'(s), cur_ch}] <= new_byte[s];
      end
    end
  end

  // read side: forward the byte completing this cycle when it is requested
  always_comb begin
    for (int r = 0; r < NSTREAM; r++) begin
      if (byte_end && (rd_bank == wbank) && (rd_addr[r][CW-1:0] == cur_ch))
        rd_byte[r] = new_byte[rd_addr[r][AW-1:CW]];
      else
        rd_byte[r] = dmem[rd_bank][rd_addr[r]];
    end
  end

  // R8: the writing bank is only read when the frame's last byte completes
  p_fwd_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && (rd_bank == wbank)) |-> (cur_ch == CW'(NCHAN - 1)));

endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int BW      = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_wr,
  input  logic [1:0]                               cfg_sel,
  input  logic [$clog2(NSTREAM)+$clog2(NCHAN)-1:0] cfg_addr,
  input  logic [BW-1:0]                            cfg_data,
  input  logic [$clog2(NCHAN)-1:0]                 rd_ch,
  output logic [NSTREAM-1:0][BW-1:0]               cml_rd,
  output cmh_t [NSTREAM-1:0]                       cmh_rd,
  output logic                                     glob_msg
);
  localparam int SW    = $clog2(NSTREAM);
  localparam int CW    = $clog2(NCHAN);
  localparam int SLOTS = 1 << (SW + CW);

  logic [BW-1:0] cml_q [SLOTS];
  cmh_t          cmh_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_msg <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        cml_q[i] <= '0;
        cmh_q[i] <= '0;
      end
    end else if (cfg_wr) begin
      case (cfg_sel)
        SEL_CML:  cml_q[cfg_addr] <= cfg_data;
        SEL_CMH:  cmh_q[cfg_addr] <= '{msg: cfg_data[CMH_MSG_BIT], oe: cfg_data[CMH_OE_BIT]};
        SEL_CTRL: glob_msg <= cfg_data[CTRL_GMSG_BIT];
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < NSTREAM; g++) begin : g_rd
    assign cml_rd[g] = cml_q[{SW'(g), rd_ch}];
    assign cmh_rd[g] = cmh_q[{SW'(g), rd_ch}];
  end

  // R3: the global message bit follows a control register write
  p_gmsg_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == SEL_CTRL) |=> (glob_msg == $past(cfg_data[CTRL_GMSG_BIT])));

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int BW      = 8
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  byte_end,
  input  logic [$clog2(NCHAN)-1:0]                              nxt_ch,
  input  logic                                                  wbank,
  input  logic                                                  glob_msg,
  input  logic [NSTREAM-1:0][BW-1:0]                            cml_rd,
  input  cmh_t [NSTREAM-1:0]                                    cmh_rd,
  input  logic [NSTREAM-1:0][BW-1:0]                            rd_byte,
  output logic                                                  rd_bank,
  output logic [NSTREAM-1:0][$clog2(NSTREAM)+$clog2(NCHAN)-1:0] rd_addr,
  output logic [NSTREAM-1:0]                                    tx_data,
  output logic [NSTREAM-1:0]                                    slot_oe
);
  localparam int AW = $clog2(NSTREAM) + $clog2(NCHAN);

  logic [NSTREAM-1:0][BW-1:0] pick;
  logic [NSTREAM-1:0]         en;
  logic [NSTREAM-1:0][BW-1:0] sh_q;

  // channel 0 of the next frame reads the bank still being filled
  assign rd_bank = (nxt_ch == '0) ? wbank : ~wbank;

  for (genvar g = 0; g < NSTREAM; g++) begin : g_slot
    assign rd_addr[g] = cml_rd[g][AW-1:0];
    assign pick[g]    = (glob_msg || cmh_rd[g].msg) ? cml_rd[g] : rd_byte[g];
    assign en[g]      = glob_msg || cmh_rd[g].oe;
    assign tx_data[g] = sh_q[g][BW-1];

    // R2: a message slot loads its connection byte unchanged
    p_msg_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && (glob_msg || cmh_rd[g].msg)) |=> (sh_q[g] == $past(cml_rd[g])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      slot_oe <= '0;
    end else if (byte_end) begin
      sh_q    <= pick;
      slot_oe <= en;
    end else begin
      for (int s = 0; s < NSTREAM; s++) sh_q[s] <= {sh_q[s][BW-2:0], 1'b0};
    end
  end

  // R3: global message drives every slot
  p_global_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && glob_msg) |=> (&slot_oe));

  // R5: a slot's enable holds across its whole byte
  p_hold_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_end |=> $stable(slot_oe));

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCHAN   = 32,
  parameter int BW      = 8
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     frame_sync,
  input  logic [NSTREAM-1:0]                       rx_data,
  input  logic                                     out_drive_en,
  input  logic                                     cfg_wr,
  input  logic [1:0]                               cfg_sel,
  input  logic [$clog2(NSTREAM)+$clog2(NCHAN)-1:0] cfg_addr,
  input  logic [BW-1:0]                            cfg_data,
  output logic [NSTREAM-1:0]                       tx_data,
  output logic [NSTREAM-1:0]                       tx_oe
);
  localparam int CW = $clog2(NCHAN);
  localparam int AW = $clog2(NSTREAM) + CW;

  logic [CW-1:0]              cur_ch, nxt_ch;
  logic                       byte_end, frame_start, wbank, rd_bank, glob_msg;
  logic [NSTREAM-1:0][AW-1:0] rd_addr;
  logic [NSTREAM-1:0][BW-1:0] rd_byte, cml_rd;
  cmh_t [NSTREAM-1:0]         cmh_rd;
  logic [NSTREAM-1:0]         slot_oe;

  tsi_timing #(.NCHAN(NCHAN), .BW(BW)) u_timing (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .cur_ch(cur_ch), .nxt_ch(nxt_ch), .byte_end(byte_end),
    .frame_start(frame_start), .wbank(wbank)
  );

  tsi_rx #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .BW(BW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .byte_end(byte_end),
    .cur_ch(cur_ch), .wbank(wbank), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  tsi_cmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .BW(BW)) u_cmem (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .rd_ch(nxt_ch),
    .cml_rd(cml_rd), .cmh_rd(cmh_rd), .glob_msg(glob_msg)
  );

  tsi_tx #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .BW(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .byte_end(byte_end), .nxt_ch(nxt_ch),
    .wbank(wbank), .glob_msg(glob_msg), .cml_rd(cml_rd), .cmh_rd(cmh_rd),
    .rd_byte(rd_byte), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .tx_data(tx_data), .slot_oe(slot_oe)
  );

  assign tx_oe = {NSTREAM{out_drive_en}} & slot_oe;

  // R4: the drive pin silences every output
  p_ode_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_drive_en |-> (tx_oe == '0));

  // R7: an enable needs a prior write or the global bit
  p_reset_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(slot_oe[0]) && !glob_msg) |-> $past(byte_end));

  logic unused_fs;
  assign unused_fs = frame_start;

endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int NS = 4;
  localparam int NC = 4;
  localparam int BW = 8;
  localparam int SLOTS = NS * NC;
  localparam int FBITS = NC * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_sync = 1'b0;
  logic [NS-1:0] rx_data = '0;
  logic          out_drive_en = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [3:0]    cfg_addr = '0;
  logic [7:0]    cfg_data = '0;
  logic [NS-1:0] tx_data, tx_oe;

  logic [7:0] m_cml [SLOTS];
  logic       m_oe  [SLOTS];
  logic       m_msg [SLOTS];
  logic       m_g;
  int wi, gf, checks, errors;

  always #4 clk = ~clk;

  tsi_switch #(.NSTREAM(NS), .NCHAN(NC), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_data(rx_data),
    .out_drive_en(out_drive_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .tx_data(tx_data), .tx_oe(tx_oe)
  );

  function automatic logic [7:0] in_byte(int f, int s, int c);
    return 8'((f * 29 + s * 67 + c * 13 + 5) & 255);
  endfunction

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic drive_write;
    cfg_wr = 1'b0;
    if (wi < SLOTS) begin
      cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_addr = 4'(wi); cfg_data = m_cml[wi];
    end else if (wi < 2 * SLOTS) begin
      cfg_wr = 1'b1; cfg_sel = 2'd1; cfg_addr = 4'(wi - SLOTS);
      cfg_data = {5'b0, m_msg[wi - SLOTS], 1'b0, m_oe[wi - SLOTS]};
    end else if (wi == 2 * SLOTS) begin
      cfg_wr = 1'b1; cfg_sel = 2'd2; cfg_addr = '0; cfg_data = {1'b0, m_g, 6'b0};
    end
    if (wi <= 2 * SLOTS) wi++;
  endtask

  task automatic check_model(int s, int c, int b);
    int slot, src;
    logic eoe;
    logic [7:0] eb;
    string tag;
    slot = s * NC + c;
    eb = '0;
    if (!out_drive_en) begin eoe = 1'b0; tag = "R4"; end
    else if (m_g) begin eoe = 1'b1; eb = m_cml[slot]; tag = "R3"; end
    else if (!m_oe[slot]) begin eoe = 1'b0; tag = "R5"; end
    else if (m_msg[slot]) begin eoe = 1'b1; eb = m_cml[slot]; tag = "R2"; end
    else begin
      eoe = 1'b1;
      src = int'(m_cml[slot][3:0]);
      eb = in_byte(gf - 1, src >> 2, src & 3);
      if (c == 0 && (src & 3) == NC - 1) tag = "R8";
      else if (b == 0) tag = "R6";
      else tag = "R1";
    end
    checks++;
    if (tx_oe[s] !== eoe || (eoe && tx_data[s] !== eb[7 - b])) begin
      errors++;
      $display("FAIL %s stream %0d ch %0d bit %0d: oe %b data %b, expected oe %b data %b",
               tag, s, c, b, tx_oe[s], tx_data[s], eoe, eb[7 - b]);
    end
  endtask

  // mode 0: no check, 1: compare with model, 2: expect silent outputs (R7)
  task automatic run_frame(int mode);
    for (int p = 0; p < FBITS; p++) begin
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
        if (mode == 1) check_model(s, p / BW, p % BW);
        else if (mode == 2) begin
          checks++;
          if (tx_oe[s] !== 1'b0) begin
            errors++;
            $display("FAIL R7 stream %0d pos %0d: oe %b, expected 0", s, p, tx_oe[s]);
          end
        end
      end
      frame_sync = (p == 0);
      for (int s = 0; s < NS; s++) rx_data[s] = in_byte(gf, s, p / BW)[7 - (p % BW)];
      drive_write();
    end
    gf++;
  endtask

  task automatic stage(logic ode);
    out_drive_en = ode;
    wi = 0;
    run_frame(0);
    run_frame(0);
    run_frame(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    errors++;
    report();
    $finish;
  end

  initial begin
    checks = 0; errors = 0; gf = 0; wi = 2 * SLOTS + 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    out_drive_en = 1'b1;
    run_frame(2);
    run_frame(2);

    // switching: every source reaches every slot (R1, R6, R8)
    for (int k = 0; k < SLOTS; k++) begin
      for (int i = 0; i < SLOTS; i++) begin
        m_cml[i] = 8'((i + k) % SLOTS); m_oe[i] = 1'b1; m_msg[i] = 1'b0;
      end
      m_g = 1'b0;
      stage(1'b1);
    end
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < SLOTS; i++) begin
        m_cml[i] = {4'hA, 4'((i * 5 + k) % SLOTS)}; m_oe[i] = 1'b1; m_msg[i] = 1'b0;
      end
      m_g = 1'b0;
      stage(1'b1);
    end
    // per-slot message mixed with switching (R2)
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < SLOTS; i++) begin
        m_cml[i] = 8'(8'hC3 ^ (i * 17 + k * 7)); m_oe[i] = 1'b1; m_msg[i] = 1'((i + k) & 1);
      end
      m_g = 1'b0;
      stage(1'b1);
    end
    // drive pin, global message and slot enable combinations (R3, R4, R5)
    for (int cmb = 0; cmb < 8; cmb++) begin
      for (int i = 0; i < SLOTS; i++) begin
        m_cml[i] = 8'((i * 7 + cmb * 3) & 255);
        m_oe[i]  = 1'(i ^ (cmb >> 2));
        m_msg[i] = 1'(i >> 1);
      end
      m_g = 1'(cmb >> 1);
      stage(1'(cmb));
    end

    report();
    $finish;
  end
endmodule